// File: doc/BRIEF.md
# Spare-Lane Shift Repair Mux

This block sits between the core-side data lanes of a die-to-die link and the physical lanes that cross the package. It has more physical lanes than logical ones, and the extra lanes act as spares. A repair mask gives one bit per physical lane, and a 1 marks that lane defective. Each logical lane is shifted upward past every defective lane, so the link keeps its full width as long as the number of defects does not exceed the spare count.

The transmit path and the receive path use the same mapping. A die that sends and a die that receives, each loaded with the same mask, therefore agree on which physical lane carries which logical lane. The drivers of defective lanes are placed in standby. Spares that the mapping leaves unused drive zero and are also placed in standby, unless a spare-test control releases them.

The block reports two status values. One flag shows that the mask holds more defects than the spares can cover. A count shows how many spares are still unused, so that parts can be binned by the repair capacity they have left. The mask only takes effect when a load strobe is given, so traffic never sees the mapping change while data is moving.

Top module: `lrep_lane_repair`

## Requirements
- R1: After reset the held mask is all zero. Physical lane p carries logical lane p for p < NL. The top NS physical lanes are in standby, `spares_left` equals NS, and `repair_ovf` is 0.
- R2: The held mask takes the value of `mask_in` only at a rising clock edge where `mask_load` is 1. At any other time, changes on `mask_in` have no effect on any output.
- R3: When there is no overflow, physical lane p carries logical lane k, where k is the number of good lanes below p, as long as p is good and k < NL. All NL logical lanes are carried.
- R4: When there is no overflow, `rx_data[k]` equals `rx_phy` on the physical lane that carries logical lane k under R3.
- R5: Any physical lane that carries no logical lane, whether it is defective or an unused spare, drives 0 on `tx_phy`.
- R6: When there is no overflow, every physical lane whose mask bit is 1 has its `phy_standby` bit set to 1.
- R7: When there is no overflow, a good physical lane that carries no logical lane is in standby when `spare_test_en` is 0. It is out of standby when `spare_test_en` is 1. Lanes that carry data are never in standby.
- R8: When there is no overflow, `spares_left` equals NS minus the number of 1 bits in the held mask.
- R9: When the held mask has more than NS bits set, `repair_ovf` is 1. The mapping is then the identity for both directions, no lane is in standby, and `spares_left` is 0.
- R10: When there is no overflow, feeding `tx_phy` back into `rx_phy` returns `tx_data` on `rx_data`. This holds whatever values appear on the defective lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_load | input | 1 | Strobe that captures `mask_in` into the held mask |
| mask_in | input | NL+NS | Defect mask, one bit per physical lane, 1 = defective |
| spare_test_en | input | 1 | Releases unused good spares from standby |
| tx_data | input | NL | Logical transmit lanes |
| tx_phy | output | NL+NS | Physical transmit lanes |
| rx_phy | input | NL+NS | Physical receive lanes |
| rx_data | output | NL | Logical receive lanes |
| phy_standby | output | NL+NS | Per-lane driver standby enable |
| repair_ovf | output | 1 | More defects than spares |
| spares_left | output | clog2(NS+1) | Count of unused spares |

## Verification
The hardest condition to reach from the ports is a mask in which the defective lanes sit among the spares themselves, or at both ends of the range. In that case the shift runs out of good lanes exactly at the top and must leave no extra lane in standby. Random masks with zero to three defects rarely produce these cases, so directed masks place defects on lanes 0, 31, the two spares, and adjacent pairs. The loopback check then corrupts only the defective lanes, which shows that no logical lane is read from them.

// File: rtl/lrep_pkg.sv
package lrep_pkg;
    localparam int DEF_LOG_LANES   = 30;
    localparam int DEF_SPARE_LANES = 2;

    typedef enum logic [0:0] {
        MAP_IDENTITY = 1'b0,
        MAP_SHIFTED  = 1'b1
    } map_mode_e;
endpackage

// File: rtl/lrep_lane_map.sv
module lrep_lane_map
    import lrep_pkg::*;
#(
    parameter int NL = DEF_LOG_LANES,
    parameter int NS = DEF_SPARE_LANES,
    localparam int NP = NL + NS,
    localparam int IW = $clog2(NP),
    localparam int CW = $clog2(NP + 1)
) (
    input  logic [NP-1:0]          mask,
    output map_mode_e              mode,
    output logic [CW-1:0]          bad_cnt,
    output logic [NP-1:0]          used,
    output logic [NP-1:0][IW-1:0]  phy_src,
    output logic [NL-1:0][IW-1:0]  log_dst
);
    logic [CW-1:0] good;
    logic          ovf;

    always_comb begin
        bad_cnt = '0;
        for (int p = 0; p < NP; p++) begin
            bad_cnt = bad_cnt + CW'(mask[p]);
        end
        ovf  = (bad_cnt > CW'(NS));
        mode = ovf ? MAP_IDENTITY : MAP_SHIFTED;

        good = '0;
        for (int p = 0; p < NP; p++) begin
            used[p]    = 1'b0;
            phy_src[p] = '0;
            if (ovf) begin
                if (p < NL) begin
                    used[p]    = 1'b1;
                    phy_src[p] = IW'(p);
                end
            end else begin
                if (!mask[p] && (good < CW'(NL))) begin
                    used[p]    = 1'b1;
                    phy_src[p] = IW'(good);
                end
                good = good + CW'(!mask[p]);
            end
        end

        for (int i = 0; i < NL; i++) begin
            log_dst[i] = IW'(i);
            if (!ovf) begin
                for (int p = 0; p < NP; p++) begin
                    if (used[p] && (phy_src[p] == IW'(i))) begin
                        log_dst[i] = IW'(p);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lrep_tx_steer.sv
module lrep_tx_steer
    import lrep_pkg::*;
#(
    parameter int NL = DEF_LOG_LANES,
    parameter int NS = DEF_SPARE_LANES,
    localparam int NP = NL + NS,
    localparam int IW = $clog2(NP)
) (
    input  logic [NL-1:0]          tx_data,
    input  logic [NP-1:0]          used,
    input  logic [NP-1:0][IW-1:0]  phy_src,
    output logic [NP-1:0]          tx_phy
);
    for (genvar p = 0; p < NP; p++) begin : g_phy
        assign tx_phy[p] = used[p] ? tx_data[phy_src[p]] : 1'b0;
    end
endmodule

// File: rtl/lrep_rx_steer.sv
module lrep_rx_steer
    import lrep_pkg::*;
#(
    parameter int NL = DEF_LOG_LANES,
    parameter int NS = DEF_SPARE_LANES,
    localparam int NP = NL + NS,
    localparam int IW = $clog2(NP)
) (
    input  logic [NP-1:0]          rx_phy,
    input  logic [NL-1:0][IW-1:0]  log_dst,
    output logic [NL-1:0]          rx_data
);
    for (genvar i = 0; i < NL; i++) begin : g_log
        assign rx_data[i] = rx_phy[log_dst[i]];
    end
endmodule

// File: rtl/lrep_lane_repair.sv
module lrep_lane_repair
    import lrep_pkg::*;
#(
    parameter int NL = DEF_LOG_LANES,
    parameter int NS = DEF_SPARE_LANES,
    localparam int NP = NL + NS,
    localparam int IW = $clog2(NP),
    localparam int CW = $clog2(NP + 1),
    localparam int SW = $clog2(NS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_load,
    input  logic [NP-1:0] mask_in,
    input  logic          spare_test_en,
    input  logic [NL-1:0] tx_data,
    output logic [NP-1:0] tx_phy,
    input  logic [NP-1:0] rx_phy,
    output logic [NL-1:0] rx_data,
    output logic [NP-1:0] phy_standby,
    output logic          repair_ovf,
    output logic [SW-1:0] spares_left
);
    typedef struct packed {
        logic [NP-1:0] mask;
    } regs_t;

    regs_t r_d, r_q;

    map_mode_e                mode;
    logic [CW-1:0]            bad_cnt;
    logic [NP-1:0]            lane_used;
    logic [NP-1:0][IW-1:0]    phy_src;
    logic [NL-1:0][IW-1:0]    log_dst;

    always_comb begin
        r_d = r_q;
        if (mask_load) begin
            r_d.mask = mask_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    lrep_lane_map #(.NL(NL), .NS(NS)) u_map (
        .mask    (r_q.mask),
        .mode    (mode),
        .bad_cnt (bad_cnt),
        .used    (lane_used),
        .phy_src (phy_src),
        .log_dst (log_dst)
    );

    lrep_tx_steer #(.NL(NL), .NS(NS)) u_tx (
        .tx_data (tx_data),
        .used    (lane_used),
        .phy_src (phy_src),
        .tx_phy  (tx_phy)
    );

    lrep_rx_steer #(.NL(NL), .NS(NS)) u_rx (
        .rx_phy  (rx_phy),
        .log_dst (log_dst),
        .rx_data (rx_data)
    );

    always_comb begin
        repair_ovf = (mode == MAP_IDENTITY);
        if (repair_ovf) begin
            phy_standby = '0;
            spares_left = '0;
        end else begin
            phy_standby = r_q.mask | (~lane_used & ~r_q.mask & {NP{~spare_test_en}});
            spares_left = SW'(CW'(NS) - bad_cnt);
        end
    end

    // R2: no strobe, no change of status
    a_r2_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_load |=> ($stable(spares_left) && $stable(repair_ovf)));

    // R3: full width carried when repairable
    a_r3_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        !repair_ovf |-> ($countones(lane_used) == NL));

    // R5: idle physical lanes quiet
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((tx_phy & ~lane_used) == '0));

    // R6: defective lanes parked
    a_r6_bad_standby: assert property (@(posedge clk) disable iff (!rst_n)
        !repair_ovf |-> ((phy_standby & r_q.mask) == r_q.mask));

    // R7: data-carrying lanes never parked
    a_r7_used_active: assert property (@(posedge clk) disable iff (!rst_n)
        !repair_ovf |-> ((phy_standby & lane_used) == '0));

    // R8: spare count consistent with mask
    a_r8_spares: assert property (@(posedge clk) disable iff (!rst_n)
        !repair_ovf |-> ((int'(spares_left) + $countones(r_q.mask)) == NS));

    // R9: overflow quiets standby and count
    a_r9_ovf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        repair_ovf |-> ((phy_standby == '0) && (spares_left == '0)));
endmodule

// File: tb/sim_lrep_lane_repair.sv
module sim_lrep_lane_repair;
    localparam int  NL = 30;
    localparam int  NS = 2;
    localparam int  NP = NL + NS;
    localparam int  SW = $clog2(NS + 1);
    localparam time CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mask_load = 1'b0;
    logic [NP-1:0] mask_in = '0;
    logic          spare_test_en = 1'b0;
    logic [NL-1:0] tx_data = '0;
    logic [NP-1:0] tx_phy;
    logic [NP-1:0] rx_phy = '0;
    logic [NL-1:0] rx_data;
    logic [NP-1:0] phy_standby;
    logic          repair_ovf;
    logic [SW-1:0] spares_left;

    int            errs = 0;
    int            checks = 0;
    bit            done = 1'b0;
    logic [NP-1:0] cur_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lrep_lane_repair #(.NL(NL), .NS(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .mask_load(mask_load), .mask_in(mask_in),
        .spare_test_en(spare_test_en), .tx_data(tx_data), .tx_phy(tx_phy),
        .rx_phy(rx_phy), .rx_data(rx_data), .phy_standby(phy_standby),
        .repair_ovf(repair_ovf), .spares_left(spares_left)
    );

    function automatic bit m_ovf(logic [NP-1:0] m);
        return $countones(m) > NS;
    endfunction

    function automatic logic [NP-1:0] m_tx(logic [NP-1:0] m, logic [NL-1:0] d);
        logic [NP-1:0] o = '0;
        int k = 0;
        if (m_ovf(m)) begin
            for (int p = 0; p < NL; p++) o[p] = d[p];
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (!m[p] && k < NL) begin o[p] = d[k]; k++; end
            end
        end
        return o;
    endfunction

    function automatic logic [NL-1:0] m_rx(logic [NP-1:0] m, logic [NP-1:0] ph);
        logic [NL-1:0] o = '0;
        int k = 0;
        if (m_ovf(m)) begin
            for (int i = 0; i < NL; i++) o[i] = ph[i];
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (!m[p] && k < NL) begin o[k] = ph[p]; k++; end
            end
        end
        return o;
    endfunction

    function automatic logic [NP-1:0] m_sb(logic [NP-1:0] m, bit test);
        logic [NP-1:0] o = '0;
        int k = 0;
        if (!m_ovf(m)) begin
            for (int p = 0; p < NP; p++) begin
                if (m[p]) o[p] = 1'b1;
                else if (k < NL) k++;
                else o[p] = !test;
            end
        end
        return o;
    endfunction

    function automatic int m_spares(logic [NP-1:0] m);
        return m_ovf(m) ? 0 : NS - $countones(m);
    endfunction

    function automatic logic [NP-1:0] rand_mask(int nbad);
        logic [NP-1:0] m = '0;
        while ($countones(m) < nbad) m[$urandom % NP] = 1'b1;
        return m;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply_mask(logic [NP-1:0] m);
        @(negedge clk);
        mask_in = m;
        mask_load = 1'b1;
        @(negedge clk);
        mask_load = 1'b0;
        cur_mask = m;
    endtask

    task automatic run_vector(bit test);
        logic [NP-1:0] noise;
        spare_test_en = test;
        tx_data = NL'($urandom);
        rx_phy = NP'($urandom);
        #1;
        chk("R3/R5 tx map", 64'(tx_phy), 64'(m_tx(cur_mask, tx_data)));
        chk("R4 rx map", 64'(rx_data), 64'(m_rx(cur_mask, rx_phy)));
        chk("R6/R7 standby", 64'(phy_standby), 64'(m_sb(cur_mask, test)));
        chk("R8 spares_left", 64'(spares_left), 64'(m_spares(cur_mask)));
        chk("R9 overflow flag", 64'(repair_ovf), 64'(m_ovf(cur_mask)));
        if (!m_ovf(cur_mask)) begin
            noise = NP'($urandom);
            rx_phy = tx_phy ^ (noise & cur_mask);
            #1;
            chk("R10 loopback", 64'(rx_data), 64'(tx_data));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        tx_data = NL'($urandom);
        #1;
        chk("R1 standby", 64'(phy_standby), 64'({{NS{1'b1}}, {NL{1'b0}}}));
        chk("R1 spares_left", 64'(spares_left), 64'(NS));
        chk("R1 overflow", 64'(repair_ovf), 64'd0);
        chk("R1 identity tx", 64'(tx_phy), 64'({{NS{1'b0}}, tx_data}));

        // R2 load only on strobe
        apply_mask(NP'(1) << 17);
        run_vector(1'b0);
        @(negedge clk);
        mask_in = rand_mask(3);
        repeat (3) @(negedge clk);
        chk("R2 spares unchanged", 64'(spares_left), 64'(NS - 1));
        chk("R2 ovf unchanged", 64'(repair_ovf), 64'd0);
        run_vector(1'b0);

        // directed corner masks
        apply_mask(NP'(1));              run_vector(1'b0);
        apply_mask(NP'(1) << (NP - 1));  run_vector(1'b0);
        apply_mask(NP'(3) << 5);         run_vector(1'b0);
        apply_mask(NP'(3));              run_vector(1'b1);
        apply_mask(NP'(3) << NL);        run_vector(1'b0);
        apply_mask('0);                  run_vector(1'b1);
        chk("R7 spares released", 64'(phy_standby), 64'd0);
        apply_mask(NP'(7) << 10);        run_vector(1'b0);
        chk("R9 ovf set", 64'(repair_ovf), 64'd1);
        apply_mask('1);                  run_vector(1'b1);

        // random masks
        for (int n = 0; n < 400; n++) begin
            apply_mask(rand_mask(int'($urandom % 4)));
            run_vector(1'($urandom));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule